// File: doc/BRIEF.md
# Calorimeter Tower Cluster Finder

This block takes one frame of calorimeter trigger towers, where each tower carries an electromagnetic and a hadronic energy. It removes low-energy noise by zeroing any tower below a programmable threshold, with a separate threshold for each energy type. It then forms a 2x2 tower cluster anchored at every position of the cluster grid. Neighbouring clusters overlap, so a single tower can contribute to up to four clusters.

The tower frame is one row and one column larger than the cluster grid. The extra row and column form a halo that comes from the neighbouring region, so the clusters on the far edges are complete. When the region lies on the detector boundary, two flags make the halo row or the halo column read as zero.

Each cluster record holds an electromagnetic sum, a hadronic sum and their total. Every sum saturates at the all-ones value of the output width. The block is fully pipelined and accepts a new frame on every cycle. Each input frame produces exactly one output strobe, a fixed number of cycles later.

Top module: `calo_cluster_finder`

## Requirements
- R1: During and after reset, `clus_vld` is low and all three cluster outputs are zero until the first frame emerges.
- R2: A tower energy strictly below its threshold (`thr_em` for electromagnetic, `thr_had` for hadronic) counts as zero. An energy equal to or above the threshold counts at its full value. Thresholds are sampled in the same cycle as `frame_vld`.
- R3: Tower (r,c), with r in 0..ROWS and c in 0..COLS, sits at flat index i = r*(COLS+1)+c, in bits [i*EW +: EW] of `tower_em` and `tower_had`. Cluster (r,c), with r < ROWS and c < COLS, sums towers (r,c), (r,c+1), (r+1,c) and (r+1,c+1). It is output in bits [(r*COLS+c)*SW +: SW].
- R4: Row ROWS and column COLS are halo. While `halo_row_off` is high, every tower in row ROWS reads as zero. While `halo_col_off` is high, every tower in column COLS reads as zero. Both flags are sampled with `frame_vld`.
- R5: The electromagnetic and hadronic cluster sums are kept apart. `clus_tot` equals the electromagnetic sum plus the hadronic sum, both taken after clipping.
- R6: Every sum that exceeds 2^SW-1 outputs 2^SW-1 instead of wrapping.
- R7: `clus_vld` is high exactly 4 clock cycles after each cycle in which `frame_vld` is high, for exactly one cycle per frame. This also holds for frames on consecutive cycles.
- R8: While `clus_vld` is low, the cluster outputs hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_vld | input | 1 | Tower frame present this cycle |
| tower_em | input | (ROWS+1)*(COLS+1)*EW | Electromagnetic tower energies, including halo |
| tower_had | input | (ROWS+1)*(COLS+1)*EW | Hadronic tower energies, including halo |
| thr_em | input | EW | Electromagnetic tower threshold |
| thr_had | input | EW | Hadronic tower threshold |
| halo_row_off | input | 1 | Force the halo row to zero |
| halo_col_off | input | 1 | Force the halo column to zero |
| clus_vld | output | 1 | Cluster records valid |
| clus_em | output | ROWS*COLS*SW | Electromagnetic cluster sums |
| clus_had | output | ROWS*COLS*SW | Hadronic cluster sums |
| clus_tot | output | ROWS*COLS*SW | Total cluster sums |

## Verification
The assertions check several properties on every cycle:
- the strobe follows each frame by exactly four cycles;
- no tower surviving the gate lies below the threshold it was sampled with;
- the outputs hold still between strobes;
- a total is never smaller than either of its parts.

Only the scoreboard scenarios can show the following:
- that each cluster gathers the right four towers, in particular across the halo;
- that a tower at exactly the threshold is kept;
- that the dead-halo flags clear the correct row and column;
- that saturation yields the clipped value rather than some other bounded number.

// File: rtl/calo_pkg.sv
package calo_pkg;
  localparam int PIPE_LAT = 4;

  function automatic int clip_to(input int v, input int w);
    int lim;
    lim = (1 << w) - 1;
    return (v > lim) ? lim : v;
  endfunction
endpackage

// File: rtl/calo_tower_gate.sv
module calo_tower_gate #(
  parameter int N  = 4,
  parameter int EW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_vld,
  input  logic [N*EW-1:0] raw,
  input  logic [EW-1:0] thr,
  input  logic [N-1:0]  kill,
  output logic [N*EW-1:0] gated,
  output logic          out_vld
);
  always_ff @(posedge clk) begin
    if (rst) out_vld <= 1'b0;
    else     out_vld <= in_vld;
  end

  for (genvar i = 0; i < N; i++) begin : g_tw
    always_ff @(posedge clk) begin
      if (rst)
        gated[i*EW +: EW] <= '0;
      else if (in_vld)
        gated[i*EW +: EW] <= (kill[i] || raw[i*EW +: EW] < thr) ? '0 : raw[i*EW +: EW];
    end

    // R2
    gate_floor_chk: assert property (@(posedge clk) disable iff (rst)
      (out_vld && $past(in_vld)) |-> (gated[i*EW +: EW] == '0 || gated[i*EW +: EW] >= $past(thr)));
  end
endmodule

// File: rtl/calo_quad_sum.sv
module calo_quad_sum
  import calo_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  parameter int EW   = 8,
  parameter int SW   = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic in_vld,
  input  logic [(ROWS+1)*(COLS+1)*EW-1:0] towers,
  output logic [ROWS*COLS*SW-1:0] quads,
  output logic out_vld
);
  localparam int TC = COLS + 1;
  localparam int PW = EW + 1;
  localparam int QW = EW + 2;

  logic [(ROWS+1)*COLS*PW-1:0] pairs;
  logic vld_a;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_a   <= 1'b0;
      out_vld <= 1'b0;
    end else begin
      vld_a   <= in_vld;
      out_vld <= vld_a;
    end
  end

  for (genvar r = 0; r <= ROWS; r++) begin : g_pr
    for (genvar c = 0; c < COLS; c++) begin : g_pc
      always_ff @(posedge clk) begin
        if (rst) pairs[(r*COLS+c)*PW +: PW] <= '0;
        else     pairs[(r*COLS+c)*PW +: PW] <= PW'(towers[(r*TC+c)*EW +: EW])
                                             + PW'(towers[(r*TC+c+1)*EW +: EW]);
      end
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_qr
    for (genvar c = 0; c < COLS; c++) begin : g_qc
      logic [QW-1:0] raw_q;
      assign raw_q = QW'(pairs[(r*COLS+c)*PW +: PW]) + QW'(pairs[((r+1)*COLS+c)*PW +: PW]);
      always_ff @(posedge clk) begin
        if (rst) quads[(r*COLS+c)*SW +: SW] <= '0;
        else     quads[(r*COLS+c)*SW +: SW] <= SW'(clip_to(int'(raw_q), SW));
      end
    end
  end

  // R7
  quad_lat_chk: assert property (@(posedge clk) disable iff (rst)
    out_vld == $past(in_vld, 2));
endmodule

// File: rtl/calo_cluster_finder.sv
module calo_cluster_finder
  import calo_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  parameter int EW   = 8,
  parameter int SW   = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_vld,
  input  logic [(ROWS+1)*(COLS+1)*EW-1:0] tower_em,
  input  logic [(ROWS+1)*(COLS+1)*EW-1:0] tower_had,
  input  logic [EW-1:0] thr_em,
  input  logic [EW-1:0] thr_had,
  input  logic halo_row_off,
  input  logic halo_col_off,
  output logic clus_vld,
  output logic [ROWS*COLS*SW-1:0] clus_em,
  output logic [ROWS*COLS*SW-1:0] clus_had,
  output logic [ROWS*COLS*SW-1:0] clus_tot
);
  localparam int NT = (ROWS + 1) * (COLS + 1);
  localparam int NC = ROWS * COLS;

  logic [NT-1:0] kill;
  for (genvar r = 0; r <= ROWS; r++) begin : g_kr
    for (genvar c = 0; c <= COLS; c++) begin : g_kc
      assign kill[r*(COLS+1)+c] = (r == ROWS && halo_row_off) || (c == COLS && halo_col_off);
    end
  end

  logic [NT*EW-1:0] em_g, had_g;
  logic em_gv, had_gv;
  logic [NC*SW-1:0] em_q, had_q;
  logic em_qv, had_qv;

  calo_tower_gate #(.N(NT), .EW(EW)) em_gate_i (
    .clk(clk), .rst(rst), .in_vld(frame_vld), .raw(tower_em), .thr(thr_em),
    .kill(kill), .gated(em_g), .out_vld(em_gv));
  calo_tower_gate #(.N(NT), .EW(EW)) had_gate_i (
    .clk(clk), .rst(rst), .in_vld(frame_vld), .raw(tower_had), .thr(thr_had),
    .kill(kill), .gated(had_g), .out_vld(had_gv));

  calo_quad_sum #(.ROWS(ROWS), .COLS(COLS), .EW(EW), .SW(SW)) em_quad_i (
    .clk(clk), .rst(rst), .in_vld(em_gv), .towers(em_g), .quads(em_q), .out_vld(em_qv));
  calo_quad_sum #(.ROWS(ROWS), .COLS(COLS), .EW(EW), .SW(SW)) had_quad_i (
    .clk(clk), .rst(rst), .in_vld(had_gv), .towers(had_g), .quads(had_q), .out_vld(had_qv));

  logic stage_v;
  assign stage_v = em_qv & had_qv;

  always_ff @(posedge clk) begin
    if (rst) clus_vld <= 1'b0;
    else     clus_vld <= stage_v;
  end

  for (genvar k = 0; k < NC; k++) begin : g_out
    logic [SW:0] wide_t;
    assign wide_t = (SW+1)'(em_q[k*SW +: SW]) + (SW+1)'(had_q[k*SW +: SW]);
    always_ff @(posedge clk) begin
      if (rst) begin
        clus_em[k*SW +: SW]  <= '0;
        clus_had[k*SW +: SW] <= '0;
        clus_tot[k*SW +: SW] <= '0;
      end else if (stage_v) begin
        clus_em[k*SW +: SW]  <= em_q[k*SW +: SW];
        clus_had[k*SW +: SW] <= had_q[k*SW +: SW];
        clus_tot[k*SW +: SW] <= SW'(clip_to(int'(wide_t), SW));
      end
    end

    // R5
    tot_floor_chk: assert property (@(posedge clk) disable iff (rst)
      clus_vld |-> (clus_tot[k*SW +: SW] >= clus_em[k*SW +: SW] &&
                    clus_tot[k*SW +: SW] >= clus_had[k*SW +: SW]));
  end

  // R7
  out_lat_chk: assert property (@(posedge clk) disable iff (rst)
    clus_vld == $past(frame_vld, PIPE_LAT));

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!clus_vld && !$past(rst)) |-> ($stable(clus_em) && $stable(clus_had) && $stable(clus_tot)));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> !clus_vld);
endmodule

// File: tb/calo_cluster_finder_tb_top.sv
module calo_cluster_finder_tb_top;
  localparam int ROWS = 3;
  localparam int COLS = 4;
  localparam int EW   = 8;
  localparam int SW   = 9;
  localparam int NT   = (ROWS + 1) * (COLS + 1);
  localparam int NC   = ROWS * COLS;
  localparam int LIM  = (1 << SW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_vld = 1'b0;
  logic [NT*EW-1:0] tower_em = '0, tower_had = '0;
  logic [EW-1:0] thr_em = '0, thr_had = '0;
  logic halo_row_off = 1'b0, halo_col_off = 1'b0;
  logic clus_vld;
  logic [NC*SW-1:0] clus_em, clus_had, clus_tot;

  calo_cluster_finder #(.ROWS(ROWS), .COLS(COLS), .EW(EW), .SW(SW)) dut_i (
    .clk(clk), .rst(rst), .frame_vld(frame_vld), .tower_em(tower_em), .tower_had(tower_had),
    .thr_em(thr_em), .thr_had(thr_had), .halo_row_off(halo_row_off), .halo_col_off(halo_col_off),
    .clus_vld(clus_vld), .clus_em(clus_em), .clus_had(clus_had), .clus_tot(clus_tot));

  always #10 clk = ~clk;

  typedef struct {
    int    cyc;
    string tag;
    int    em[NC];
    int    had[NC];
    int    tot[NC];
  } exp_t;

  exp_t sb_q[$];
  exp_t last;
  int   cyc = 0;
  int   total = 0;
  int   bad = 0;
  bit   have_last = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int clipv(int v);
    return (v > LIM) ? LIM : v;
  endfunction

  // Drive one frame at a negative edge and push its expected record.
  task automatic send(input string tag, input int em_v[NT], input int had_v[NT],
                      input int te, input int th, input bit row_off, input bit col_off);
    exp_t e;
    int ge[NT];
    int gh[NT];
    for (int i = 0; i < NT; i++) begin
      bit dead;
      dead  = (row_off && (i / (COLS+1)) == ROWS) || (col_off && (i % (COLS+1)) == COLS);
      ge[i] = (dead || em_v[i] < te) ? 0 : em_v[i];
      gh[i] = (dead || had_v[i] < th) ? 0 : had_v[i];
      tower_em[i*EW +: EW]  = EW'(em_v[i]);
      tower_had[i*EW +: EW] = EW'(had_v[i]);
    end
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        int a, b, d, f;
        a = r*(COLS+1)+c;
        b = a + 1;
        d = a + COLS + 1;
        f = d + 1;
        e.em[r*COLS+c]  = clipv(ge[a] + ge[b] + ge[d] + ge[f]);
        e.had[r*COLS+c] = clipv(gh[a] + gh[b] + gh[d] + gh[f]);
        e.tot[r*COLS+c] = clipv(e.em[r*COLS+c] + e.had[r*COLS+c]);
      end
    end
    thr_em       = EW'(te);
    thr_had      = EW'(th);
    halo_row_off = row_off;
    halo_col_off = col_off;
    frame_vld    = 1'b1;
    e.cyc        = cyc;
    e.tag        = tag;
    sb_q.push_back(e);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    frame_vld = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  // Monitor: compare every emerging frame with the head of the scoreboard.
  always @(negedge clk) begin
    if (!rst && clus_vld) begin
      if (sb_q.size() == 0) begin
        total++;
        bad++;
        $display("FAIL R7 unexpected strobe: actual=1 expected=0 at cycle %0d", cyc);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        total++;
        if (cyc != e.cyc + 4) begin
          bad++;
          $display("FAIL R7 strobe cycle: actual=%0d expected=%0d", cyc, e.cyc + 4);
        end
        for (int k = 0; k < NC; k++) begin
          int ae, ah, at;
          ae = int'(clus_em[k*SW +: SW]);
          ah = int'(clus_had[k*SW +: SW]);
          at = int'(clus_tot[k*SW +: SW]);
          total++;
          if (ae != e.em[k] || ah != e.had[k] || at != e.tot[k]) begin
            bad++;
            $display("FAIL %s cluster %0d: actual em=%0d had=%0d tot=%0d expected em=%0d had=%0d tot=%0d",
                     e.tag, k, ae, ah, at, e.em[k], e.had[k], e.tot[k]);
          end
        end
        last = e;
        have_last = 1;
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    int em_v[NT];
    int had_v[NT];
    repeat (3) @(negedge clk);
    // R1: quiet while in reset
    total++;
    if (clus_vld !== 1'b0 || clus_em !== '0 || clus_had !== '0 || clus_tot !== '0) begin
      bad++;
      $display("FAIL R1 reset outputs: actual vld=%0b expected vld=0 and zero sums", clus_vld);
    end
    rst = 1'b0;
    repeat (6) @(negedge clk);
    total++;
    if (clus_vld !== 1'b0 || clus_tot !== '0) begin
      bad++;
      $display("FAIL R1 after reset: actual vld=%0b expected vld=0", clus_vld);
    end

    // R3 / R2: mixed pattern, thresholds active
    for (int i = 0; i < NT; i++) begin
      em_v[i]  = (i*37 + 11) % 256;
      had_v[i] = (i*53 + 5) % 256;
    end
    send("R3", em_v, had_v, 40, 60, 0, 0);
    idle(6);

    // R2: em exactly at threshold kept, had one below dropped
    for (int i = 0; i < NT; i++) begin
      em_v[i]  = 20;
      had_v[i] = 29;
    end
    send("R2", em_v, had_v, 20, 30, 0, 0);
    idle(6);

    // R4: halo row and column dead
    for (int i = 0; i < NT; i++) begin
      em_v[i]  = 10 + i;
      had_v[i] = 3 * i;
    end
    send("R4", em_v, had_v, 0, 0, 1, 0);
    idle(6);
    send("R4", em_v, had_v, 0, 0, 0, 1);
    idle(6);
    send("R4", em_v, had_v, 0, 0, 1, 1);
    idle(6);

    // R6: saturation of every sum
    for (int i = 0; i < NT; i++) begin
      em_v[i]  = 255;
      had_v[i] = 200;
    end
    send("R6", em_v, had_v, 0, 0, 0, 0);
    idle(6);

    // R5: separate sums, total clipped only when it overflows
    for (int i = 0; i < NT; i++) begin
      em_v[i]  = (i % 3 == 0) ? 90 : 0;
      had_v[i] = (i % 2 == 0) ? 40 : 0;
    end
    send("R5", em_v, had_v, 0, 0, 0, 0);
    idle(6);

    // R7: three frames on consecutive cycles
    for (int i = 0; i < NT; i++) begin
      em_v[i]  = (i * 13) % 256;
      had_v[i] = (i * 7 + 1) % 256;
    end
    send("R7", em_v, had_v, 15, 8, 0, 0);
    @(negedge clk);
    for (int i = 0; i < NT; i++) em_v[i] = 255 - em_v[i];
    send("R7", em_v, had_v, 50, 0, 1, 0);
    @(negedge clk);
    for (int i = 0; i < NT; i++) had_v[i] = 128;
    send("R7", em_v, had_v, 0, 129, 0, 1);
    idle(8);

    // R8: outputs hold the last frame while idle, even as inputs change
    for (int i = 0; i < NT; i++) begin
      tower_em[i*EW +: EW]  = 8'hAA;
      tower_had[i*EW +: EW] = 8'h55;
    end
    repeat (5) @(negedge clk);
    for (int k = 0; k < NC; k++) begin
      total++;
      if (!have_last || int'(clus_em[k*SW +: SW]) != last.em[k] ||
          int'(clus_had[k*SW +: SW]) != last.had[k] || int'(clus_tot[k*SW +: SW]) != last.tot[k]) begin
        bad++;
        $display("FAIL R8 hold cluster %0d: actual tot=%0d expected tot=%0d",
                 k, int'(clus_tot[k*SW +: SW]), last.tot[k]);
      end
    end

    // R7: every frame emerged
    total++;
    if (sb_q.size() != 0) begin
      bad++;
      $display("FAIL R7 frames outstanding: actual=%0d expected=0", sb_q.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule